// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block holds the base address registers of a type-0 configuration header: six standard slots and one expansion ROM slot. Each slot's kind (I/O, 32-bit memory or 64-bit memory) and its power-of-two size are fixed by parameters at build time. A 64-bit memory BAR takes its own slot and the slot after it, which then holds the upper dword. The configuration port takes dword writes with byte lanes, selected by slot index. A combinational read port returns the dword of any slot.

Software finds a BAR's size by writing ones to its address field and reading the value back. The bank returns every bit above the natural alignment, with the type bits still in place. The bank also keeps a programmed base for each BAR, kept apart from the raw register contents. It compares each write against that base and pulses a relocation output when the base really moves. The output carries the slot index, the old and new 64-bit bases, and the last byte address of the new window. A sizing probe, and the restore of the old value after it, raise no event.

Top module: `barbank_top`

## Requirements
- R1: After reset every slot reads back only its fixed type bits (I/O 0x1, 64-bit lower dword 0x4, all others 0x0), and no relocation pulse is seen in the cycle after reset.
- R2: Type bits and bits below a BAR's size are read-only. The I/O type bit 0 always reads 1, bits [2:1] of a 64-bit lower dword always read 2'b10, and the low bits of a 32-bit memory BAR read 0 whatever is written.
- R3: After ones are written to a BAR's address field, a read returns every bit at or above log2(size) set, together with the fixed type bits. Example: a 4 KiB memory BAR reads 0xFFFFF000.
- R4: Write byte enable bit k updates only data bits [8k+7:8k]. Disabled lanes keep their previous value.
- R5: A slot whose size is zero (the default slot 4) reads 0x00000000, ignores every write and never raises a relocation.
- R6: Expansion ROM slot (index NUM_BARS, default 6): bit 0 is a writable enable, bits [10:1] read 0, and bits at or above log2(size) hold the address. A write of 0xFFFFF800 is a sizing probe and raises no event.
- R7: On an I/O, 32-bit or ROM slot, a write that leaves the address field neither all ones nor equal to the programmed base sets reloc_valid for exactly the cycle after the write edge. reloc_idx, reloc_old and reloc_new then hold the slot, the previous base and the new base, with type and enable bits cleared.
- R8: Writing back the programmed base after a sizing probe raises no event and leaves the programmed base unchanged.
- R9: A lower-dword write to a 64-bit BAR raises an event only when its address bits are not all ones and the upper dword still equals the programmed upper base. Otherwise the decision waits for the upper-dword write, which compares the combined 64-bit base.
- R10: A 64-bit BAR is treated as being sized only when both halves hold all ones in their address fields. All ones in only one half is a real new address and raises an event.
- R11: reloc_last equals reloc_new plus the BAR size minus one.
- R12: Changing only the ROM enable bit or its reserved bits raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | IW (3) | Slot written: 0..NUM_BARS-1 are BARs, NUM_BARS is the ROM |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Byte lane enables |
| cfg_rd_idx | input | IW (3) | Slot read |
| cfg_rd_data | output | 32 | Read data of slot cfg_rd_idx |
| reloc_valid | output | 1 | One-cycle relocation pulse |
| reloc_idx | output | IW (3) | Slot of the moved BAR (lower slot for 64-bit) |
| reloc_old | output | 64 | Previous programmed base |
| reloc_new | output | 64 | New programmed base |
| reloc_last | output | 64 | Last byte address of the new window |

## Verification
Ones written to each kind of slot show whether the read-back mask keeps the type bits and sits at the right alignment. Restoring the old value after a probe shows whether the programmed base is kept apart from the raw register. On the 64-bit pair the bench writes the halves in several orders: low-then-high after a probe, low only with the upper half unchanged, all ones in the upper half alone, and all ones in the lower half alone. Together these separate a true move from a probe on either half. Partial byte-lane writes, ROM enable-only changes and writes to the empty slot show whether state that should be untouched was changed.

// File: rtl/barbank_pkg.sv
`timescale 1ns/1ps
package barbank_pkg;

    localparam logic [1:0] KIND_IO  = 2'd0;
    localparam logic [1:0] KIND_M32 = 2'd1;
    localparam logic [1:0] KIND_M64 = 2'd2;

    typedef enum logic [2:0] {
        ROLE_OFF,
        ROLE_IO,
        ROLE_M32,
        ROLE_M64LO,
        ROLE_M64HI,
        ROLE_ROM
    } slot_role_e;

    typedef struct packed {
        logic [63:0] old_base;
        logic [63:0] new_base;
        logic [5:0]  szlog;
    } reloc_req_t;

    function automatic logic [31:0] wmask_of(slot_role_e r, int unsigned sz);
        logic [31:0] m;
        case (r)
            ROLE_IO, ROLE_M32: m = 32'hFFFF_FFFF << sz;
            ROLE_M64LO:        m = (sz >= 32) ? 32'h0 : (32'hFFFF_FFFF << sz);
            ROLE_M64HI:        m = (sz <= 32) ? 32'hFFFF_FFFF : (32'hFFFF_FFFF << (sz - 32));
            ROLE_ROM:          m = (32'hFFFF_FFFF << sz) | 32'h1;
            default:           m = 32'h0;
        endcase
        return m;
    endfunction

    function automatic logic [31:0] amask_of(slot_role_e r, int unsigned sz);
        return wmask_of(r, sz) & ((r == ROLE_ROM) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF);
    endfunction

    function automatic logic [31:0] fixed_of(slot_role_e r);
        logic [31:0] f;
        case (r)
            ROLE_IO:    f = 32'h1;
            ROLE_M64LO: f = 32'h4;
            default:    f = 32'h0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/barbank_slot.sv
`timescale 1ns/1ps
module barbank_slot #(
    parameter logic [31:0] WMASK = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [31:0] wr_val,
    input  logic        pl,
    input  logic [31:0] pl_val,
    output logic [31:0] raw,
    output logic [31:0] prog
);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            prog <= '0;
        end else begin
            if (wr) raw <= wr_val;
            if (pl) prog <= pl_val;
        end
    end

    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(raw)) else $error("raw changed without write"); // R4

    AST_RAW_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        (raw & ~WMASK) == 32'h0) else $error("read-only bit stored"); // R2

    AST_PROG_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        (prog & ~WMASK) == 32'h0) else $error("base outside mask"); // R5

endmodule

// File: rtl/barbank_reloc.sv
`timescale 1ns/1ps
module barbank_reloc
    import barbank_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [IW-1:0] idx,
    input  reloc_req_t    req,
    output logic          valid,
    output logic [IW-1:0] out_idx,
    output logic [63:0]   out_old,
    output logic [63:0]   out_new,
    output logic [63:0]   out_last
);

    logic [63:0] span;
    assign span = (64'd1 << req.szlog) - 64'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            out_idx  <= '0;
            out_old  <= '0;
            out_new  <= '0;
            out_last <= '0;
        end else begin
            valid <= fire;
            if (fire) begin
                out_idx  <= idx;
                out_old  <= req.old_base;
                out_new  <= req.new_base;
                out_last <= req.new_base + span;
            end
        end
    end

endmodule

// File: rtl/barbank_top.sv
`timescale 1ns/1ps
module barbank_top
    import barbank_pkg::*;
#(
    parameter int          NUM_BARS  = 6,
    parameter logic [11:0] BAR_KIND  = {KIND_IO, KIND_M32, KIND_IO, KIND_M64, KIND_IO, KIND_M32},
    parameter logic [35:0] BAR_SZLOG = {6'd8, 6'd0, 6'd0, 6'd20, 6'd5, 6'd12},
    parameter int          ROM_SZLOG = 16,
    localparam int         NSLOT     = NUM_BARS + 1,
    localparam int         IW        = $clog2(NSLOT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr_en,
    input  logic [IW-1:0] cfg_wr_idx,
    input  logic [31:0]   cfg_wr_data,
    input  logic [3:0]    cfg_wr_be,
    input  logic [IW-1:0] cfg_rd_idx,
    output logic [31:0]   cfg_rd_data,
    output logic          reloc_valid,
    output logic [IW-1:0] reloc_idx,
    output logic [63:0]   reloc_old,
    output logic [63:0]   reloc_new,
    output logic [63:0]   reloc_last
);

    // Slot role: walks the slots so that a 64-bit BAR claims its neighbour.
    function automatic slot_role_e role_of(int s);
        slot_role_e r;
        logic       upper;
        logic       found;
        r     = ROLE_OFF;
        upper = 1'b0;
        found = 1'b0;
        if (s == NUM_BARS) begin
            r     = (ROM_SZLOG != 0) ? ROLE_ROM : ROLE_OFF;
            found = 1'b1;
        end
        for (int j = 0; j < NUM_BARS; j++) begin
            if (!found && j == s) begin
                found = 1'b1;
                if (upper) r = ROLE_M64HI;
                else if (BAR_SZLOG[6*j +: 6] == 6'd0) r = ROLE_OFF;
                else begin
                    case (BAR_KIND[2*j +: 2])
                        KIND_IO:  r = ROLE_IO;
                        KIND_M32: r = ROLE_M32;
                        KIND_M64: r = (j == NUM_BARS - 1) ? ROLE_OFF : ROLE_M64LO;
                        default:  r = ROLE_OFF;
                    endcase
                end
            end
            if (upper) upper = 1'b0;
            else upper = (BAR_KIND[2*j +: 2] == KIND_M64) && (BAR_SZLOG[6*j +: 6] != 6'd0);
        end
        return r;
    endfunction

    function automatic int unsigned szlog_of(int s);
        int unsigned v;
        if (s == NUM_BARS) v = ROM_SZLOG;
        else if (role_of(s) == ROLE_M64HI) v = BAR_SZLOG[6*((s > 0) ? s - 1 : 0) +: 6];
        else v = BAR_SZLOG[6*s +: 6];
        return v;
    endfunction

    slot_role_e  role_a [NSLOT];
    logic [31:0] wmask  [NSLOT];
    logic [31:0] amask  [NSLOT];
    logic [31:0] fixed  [NSLOT];
    logic [5:0]  szl    [NSLOT];
    logic [31:0] raw    [NSLOT];
    logic [31:0] prog   [NSLOT];
    logic [31:0] prog_nxt [NSLOT];
    logic [NSLOT-1:0] prog_ld;

    logic          hit;
    logic [IW-1:0] sel, hs, ls, rsel;
    logic [31:0]   bm, merged, cand_lo, cand_hi;
    logic          fire;
    logic [IW-1:0] ev_idx;
    reloc_req_t    req;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam slot_role_e  RL = role_of(g);
        localparam int unsigned SZ = szlog_of(g);
        localparam logic [31:0] WM = wmask_of(RL, SZ);

        assign role_a[g] = RL;
        assign wmask[g]  = WM;
        assign amask[g]  = amask_of(RL, SZ);
        assign fixed[g]  = fixed_of(RL);
        assign szl[g]    = 6'(SZ);

        barbank_slot #(.WMASK(WM)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .wr     (hit && (sel == IW'(g))),
            .wr_val (merged),
            .pl     (prog_ld[g]),
            .pl_val (prog_nxt[g]),
            .raw    (raw[g]),
            .prog   (prog[g])
        );
    end

    always_comb begin
        bm      = {{8{cfg_wr_be[3]}}, {8{cfg_wr_be[2]}}, {8{cfg_wr_be[1]}}, {8{cfg_wr_be[0]}}};
        hit     = cfg_wr_en && (cfg_wr_idx < IW'(NSLOT));
        sel     = hit ? cfg_wr_idx : '0;
        hs      = (sel == IW'(NSLOT - 1)) ? sel : sel + IW'(1);
        ls      = (sel == '0) ? sel : sel - IW'(1);
        merged  = ((raw[sel] & ~bm) | (cfg_wr_data & bm)) & wmask[sel];
        fire    = 1'b0;
        ev_idx  = sel;
        req     = '0;
        prog_ld = '0;
        cand_lo = '0;
        cand_hi = '0;
        for (int k = 0; k < NSLOT; k++) prog_nxt[k] = prog[k];
        if (hit) begin
            case (role_a[sel])
                ROLE_IO, ROLE_M32, ROLE_ROM: begin
                    cand_lo = merged & amask[sel];
                    if (cand_lo != amask[sel] && cand_lo != prog[sel]) begin
                        fire          = 1'b1;
                        prog_ld[sel]  = 1'b1;
                        prog_nxt[sel] = cand_lo;
                        req.old_base  = {32'h0, prog[sel]};
                        req.new_base  = {32'h0, cand_lo};
                        req.szlog     = szl[sel];
                    end
                end
                ROLE_M64LO: begin
                    cand_lo = merged;
                    cand_hi = raw[hs];
                    if (cand_lo != amask[sel] && raw[hs] == prog[hs] &&
                        {cand_hi, cand_lo} != {prog[hs], prog[sel]}) begin
                        fire          = 1'b1;
                        prog_ld[sel]  = 1'b1;
                        prog_ld[hs]   = 1'b1;
                        prog_nxt[sel] = cand_lo;
                        prog_nxt[hs]  = cand_hi;
                        req.old_base  = {prog[hs], prog[sel]};
                        req.new_base  = {cand_hi, cand_lo};
                        req.szlog     = szl[sel];
                    end
                end
                ROLE_M64HI: begin
                    cand_hi = merged;
                    cand_lo = raw[ls];
                    if (!(cand_hi == amask[sel] && cand_lo == amask[ls]) &&
                        {cand_hi, cand_lo} != {prog[sel], prog[ls]}) begin
                        fire          = 1'b1;
                        ev_idx        = ls;
                        prog_ld[sel]  = 1'b1;
                        prog_ld[ls]   = 1'b1;
                        prog_nxt[sel] = cand_hi;
                        prog_nxt[ls]  = cand_lo;
                        req.old_base  = {prog[sel], prog[ls]};
                        req.new_base  = {cand_hi, cand_lo};
                        req.szlog     = szl[ls];
                    end
                end
                default: ;
            endcase
        end
    end

    assign rsel        = (cfg_rd_idx < IW'(NSLOT)) ? cfg_rd_idx : '0;
    assign cfg_rd_data = (cfg_rd_idx < IW'(NSLOT)) ? (raw[rsel] | fixed[rsel]) : 32'h0;

    barbank_reloc #(.IW(IW)) u_reloc (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .idx      (ev_idx),
        .req      (req),
        .valid    (reloc_valid),
        .out_idx  (reloc_idx),
        .out_old  (reloc_old),
        .out_new  (reloc_new),
        .out_last (reloc_last)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !reloc_valid) else $error("event after reset"); // R1

    AST_RELOC_MOVES: assert property (@(posedge clk) disable iff (rst)
        reloc_valid |-> reloc_new != reloc_old) else $error("event without move"); // R7

    AST_LAST_SPAN: assert property (@(posedge clk) disable iff (rst)
        reloc_valid |-> (reloc_last >= reloc_new) &&
        (((reloc_last - reloc_new + 64'd1) & (reloc_last - reloc_new)) == 64'd0))
        else $error("window end not size-aligned"); // R11

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (hit && role_a[sel] == ROLE_OFF) |=> !reloc_valid) else $error("empty slot event"); // R5

    AST_ROM_RSVD: assert property (@(posedge clk) disable iff (rst)
        (raw[NUM_BARS] & 32'h0000_07FE) == 32'h0) else $error("ROM reserved bit set"); // R6

endmodule

// File: tb/sim_barbank_top.sv
`timescale 1ns/1ps
module sim_barbank_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        rv;
    logic [2:0]  ridx;
    logic [63:0] rold, rnew, rlast;

    always #10 clk = ~clk;

    barbank_top u0 (
        .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_wr_idx(wr_idx),
        .cfg_wr_data(wr_data), .cfg_wr_be(wr_be), .cfg_rd_idx(rd_idx),
        .cfg_rd_data(rd_data), .reloc_valid(rv), .reloc_idx(ridx),
        .reloc_old(rold), .reloc_new(rnew), .reloc_last(rlast)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string tag = "R1";

    // Reference model state
    logic [31:0] mraw  [7];
    logic [31:0] mprog [7];
    logic        mv;
    logic [2:0]  midx;
    logic [63:0] mold, mnew;

    function automatic logic [31:0] m_wm(int s);
        case (s)
            0: return 32'hFFFF_F000;
            1: return 32'hFFFF_FFE0;
            2: return 32'hFFF0_0000;
            3: return 32'hFFFF_FFFF;
            5: return 32'hFFFF_FF00;
            6: return 32'hFFFF_0001;
            default: return 32'h0;
        endcase
    endfunction
    function automatic logic [31:0] m_am(int s);
        return (s == 6) ? 32'hFFFF_0000 : m_wm(s);
    endfunction
    function automatic logic [31:0] m_fx(int s);
        case (s)
            1, 5: return 32'h1;
            2:    return 32'h4;
            default: return 32'h0;
        endcase
    endfunction
    function automatic logic [63:0] m_size(int s);
        case (s)
            0: return 64'h1000;
            1: return 64'h20;
            2: return 64'h10_0000;
            5: return 64'h100;
            default: return 64'h1_0000;
        endcase
    endfunction
    function automatic logic [31:0] m_read(int s);
        return (s < 7) ? (mraw[s] | m_fx(s)) : 32'h0;
    endfunction

    task automatic m_event(int s, logic [63:0] o, logic [63:0] n);
        mv = 1'b1; midx = 3'(s); mold = o; mnew = n;
    endtask

    always @(posedge clk) begin
        logic [31:0] lanes, nv, a;
        int i;
        cyc++;
        mv = 1'b0;
        if (rst) begin
            for (int k = 0; k < 7; k++) begin mraw[k] = '0; mprog[k] = '0; end
        end else if (wr_en && wr_idx < 3'd7) begin
            i = int'(wr_idx);
            lanes = {{8{wr_be[3]}}, {8{wr_be[2]}}, {8{wr_be[1]}}, {8{wr_be[0]}}};
            nv = ((mraw[i] & ~lanes) | (wr_data & lanes)) & m_wm(i);
            a  = nv & m_am(i);
            if (i == 2) begin
                if (a != m_am(2) && mraw[3] == mprog[3] && {mraw[3], a} != {mprog[3], mprog[2]}) begin
                    m_event(2, {mprog[3], mprog[2]}, {mraw[3], a});
                    mprog[2] = a; mprog[3] = mraw[3];
                end
            end else if (i == 3) begin
                if (!(a == 32'hFFFF_FFFF && mraw[2] == m_am(2)) && {a, mraw[2]} != {mprog[3], mprog[2]}) begin
                    m_event(2, {mprog[3], mprog[2]}, {a, mraw[2]});
                    mprog[3] = a; mprog[2] = mraw[2];
                end
            end else if (i != 4) begin
                if (a != m_am(i) && a != mprog[i]) begin
                    m_event(i, {32'h0, mprog[i]}, {32'h0, a});
                    mprog[i] = a;
                end
            end
            mraw[i] = nv;
        end
    end

    task automatic check(string t, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    // Compare every clock against the model
    always @(negedge clk) begin
        if (cyc >= 1) begin
            check({tag, " read"}, {32'h0, rd_data}, {32'h0, m_read(int'(rd_idx))});
            check({tag, " valid"}, {63'h0, rv}, {63'h0, mv});
            if (mv) begin
                check({tag, " idx"}, {61'h0, ridx}, {61'h0, midx});
                check({tag, " old"}, rold, mold);
                check({tag, " new"}, rnew, mnew);
                check({tag, " last"}, rlast, mnew + m_size(int'(midx)) - 64'd1);
            end
        end
    end

    task automatic wr(int s, logic [31:0] d, logic [3:0] be = 4'hF);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_idx = 3'(s); wr_data = d; wr_be = be;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rdx(string t, int s, logic [31:0] exp);
        @(posedge clk); #2;
        rd_idx = 3'(s);
        @(negedge clk);
        check(t, {32'h0, rd_data}, {32'h0, exp});
    endtask

    task automatic no_ev(string t);
        @(negedge clk);
        check(t, {63'h0, rv}, 64'h0);
    endtask

    task automatic ev(string t, int s, logic [63:0] o, logic [63:0] n, logic [63:0] l);
        @(negedge clk);
        check({t, " valid"}, {63'h0, rv}, 64'h1);
        check({t, " idx"}, {61'h0, ridx}, 64'(s));
        check({t, " old"}, rold, o);
        check({t, " new"}, rnew, n);
        check({t, " last"}, rlast, l);
    endtask

    logic done = 1'b0;

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset state
        tag = "R1";
        no_ev("R1 no event");
        rdx("R1 slot0", 0, 32'h0);
        rdx("R1 slot1", 1, 32'h1);
        rdx("R1 slot2", 2, 32'h4);
        rdx("R1 slot3", 3, 32'h0);
        rdx("R1 slot6", 6, 32'h0);
        // R3 sizing masks, R2 type bits kept
        tag = "R3";
        wr(0, 32'hFFFF_FFFF); no_ev("R3 probe0");
        rdx("R3 size slot0", 0, 32'hFFFF_F000);
        wr(1, 32'hFFFF_FFFF); no_ev("R3 probe1");
        rdx("R2 io type bit", 1, 32'hFFFF_FFE1);
        wr(5, 32'hFFFF_FFFF);
        rdx("R3 size slot5", 5, 32'hFFFF_FF01);
        tag = "R10";
        wr(2, 32'hFFFF_FFFF); no_ev("R10 lower ones deferred");
        wr(3, 32'hFFFF_FFFF); no_ev("R10 both halves probe");
        rdx("R2 m64 type bits", 2, 32'hFFF0_0004);
        rdx("R3 size slot3", 3, 32'hFFFF_FFFF);
        // R8 restore after probe
        tag = "R8";
        wr(0, 32'h0); no_ev("R8 restore");
        rdx("R8 slot0", 0, 32'h0);
        // R7 / R11 32-bit move
        tag = "R7";
        wr(0, 32'h1234_5678);
        ev("R7 m32 move", 0, 64'h0, 64'h1234_5000, 64'h1234_5FFF);
        rdx("R2 low bits", 0, 32'h1234_5000);
        tag = "R4";
        wr(0, 32'hAB00_0000, 4'b1000);
        ev("R4 lane3", 0, 64'h1234_5000, 64'hAB34_5000, 64'hAB34_5FFF);
        wr(0, 32'hAB34_500F); no_ev("R2 low bits only");
        tag = "R11";
        wr(1, 32'h0000_C003);
        ev("R11 io move", 1, 64'h0, 64'hC000, 64'hC01F);
        rdx("R2 io read", 1, 32'h0000_C001);
        // R9 64-bit pairing
        tag = "R9";
        wr(2, 32'h8000_0000); no_ev("R9 lower waits");
        rdx("R9 lower read", 2, 32'h8000_0004);
        wr(3, 32'h0000_0001);
        ev("R9 upper completes", 2, 64'h0, 64'h1_8000_0000, 64'h1_800F_FFFF);
        wr(2, 32'h9000_0000);
        ev("R9 lower fires", 2, 64'h1_8000_0000, 64'h1_9000_0000, 64'h1_900F_FFFF);
        tag = "R10";
        wr(3, 32'hFFFF_FFFF);
        ev("R10 upper ones", 2, 64'h1_9000_0000, 64'hFFFF_FFFF_9000_0000, 64'hFFFF_FFFF_900F_FFFF);
        wr(2, 32'hFFFF_FFFF); no_ev("R10 lower ones waits");
        wr(3, 32'h0000_0002);
        ev("R10 lower ones real", 2, 64'hFFFF_FFFF_9000_0000, 64'h2_FFF0_0000, 64'h2_FFFF_FFFF);
        // R5 empty slot
        tag = "R5";
        wr(4, 32'hFFFF_FFFF); no_ev("R5 probe");
        rdx("R5 read", 4, 32'h0);
        wr(4, 32'h1234_0000); no_ev("R5 write");
        rdx("R5 read2", 4, 32'h0);
        // R6 / R12 ROM
        tag = "R6";
        wr(6, 32'hFFFF_F800); no_ev("R6 rom probe");
        rdx("R6 rom size", 6, 32'hFFFF_0000);
        wr(6, 32'h0); no_ev("R6 rom restore");
        wr(6, 32'h000C_0001);
        ev("R6 rom move", 6, 64'h0, 64'hC_0000, 64'hC_FFFF);
        rdx("R6 rom read", 6, 32'h000C_0001);
        tag = "R12";
        wr(6, 32'h000C_07FE); no_ev("R12 enable only");
        rdx("R12 rsvd zero", 6, 32'h000C_0000);
        // R1 reset again
        tag = "R1";
        @(posedge clk); #2 rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        no_ev("R1 after reset");
        rdx("R1 slot0 again", 0, 32'h0);
        rdx("R1 slot3 again", 3, 32'h0);
        rdx("R1 slot6 again", 6, 32'h0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule